// File: doc/BRIEF.md
# Instruction-Boundary Event Priority Arbiter

This block decides, at each instruction boundary of a processor core, which single asynchronous event is serviced next. It keeps pending latches for system-management, init and non-maskable events, watches a level-sensitive maskable interrupt request and a bus-hold request, and holds the debug-trap status register. When a boundary is presented it walks a fixed priority ladder. The rungs are a task-switch debug trap, the system-management event, the init event, the pending debug traps, the non-maskable event, the maskable interrupt and the hold request. It then issues one single-cycle grant together with the vector to deliver.

Two qualifiers gate the ladder. A one-instruction shadow, opened by an instruction such as a stack-segment load or an interrupt-enable, blocks external events, debug traps or both. It is timed against an internal retired-instruction counter. A global enable gates the system-management, init and external events, and while it is clear it also strips every debug-trap bit except single-step. A maskable interrupt is not granted at once. The block first raises an acknowledge request to the interrupt controller, and it issues the grant carrying the returned vector after the controller answers. An attention output tells the core whether the boundary logic needs to be visited at all.

Top module: `evt_boundary_arbiter`

## Requirements
- R1: After reset the grant vector, grant vector value, debug-trap register, acknowledge request, NMI-blocked flag and attention output are all zero.
- R2: Each accepted boundary (bnd_valid high while no acknowledge is outstanding) yields at most one grant. The grant is a one-hot pulse on `gnt` that lasts one cycle, in the cycle after the boundary. The bit positions are 0 debug exception, 1 SMI, 2 INIT, 3 NMI, 4 INTR and 5 hold. The ladder order, highest first, is: task-switch trap (debug bit 15), SMI, INIT, debug traps (bits 15:12), NMI, INTR, hold. The vector is 1 for a debug exception, 2 for NMI, the acknowledged vector for INTR and 0 otherwise.
- R3: SMI and INIT are taken only while `gie` is high. Taking either one clears its pending latch. An `init_evt` pulse that arrives while `init_block` is high is not recorded.
- R4: Outside a debug shadow, a boundary that finds any of debug bits 15:12 set grants a debug exception, unless SMI or INIT wins, in which case the bits are kept. A boundary that finds none of these bits set clears the debug register. Inside a debug shadow the register is kept. `dbg_set` bits are ORed into the register on cycles without an accepted boundary.
- R5: At a boundary with `gie` low, every debug-trap bit except bit 14 (single-step) is discarded.
- R6: NMI, INTR and hold are not taken while the interrupt shadow is active or `gie` is low.
- R7: Taking an NMI clears NMI pending and sets `nmi_blocked`. A pending NMI is not taken while `nmi_blocked` is high. `nmi_unblock` clears the flag.
- R8: INTR is taken only with `if_flag` high. The block then holds `intack_req` high from the cycle after the boundary until `intack_vld`, and in the cycle after `intack_vld` it grants INTR with `intack_vec` as the vector. No boundary may be presented while `intack_req` is high.
- R9: A `shadow_set` records `shadow_kind` (bit 0 blocks external events, bit 1 blocks debug traps) and a limit equal to the retired count plus one. The shadow is active while the count is at or below the limit, so it covers boundaries until the second `retire` pulse after it.
- R10: A boundary with `tf_flag` high leaves bit 14 set in the debug register, in addition to the other updates.
- R11: `attention` is high when the debug register is non-zero, or hold is requested, or `gie` is high together with a pending SMI, a pending INIT, a pending unblocked NMI, or an INTR request with `if_flag` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bnd_valid | input | 1 | Instruction boundary is presented this cycle |
| retire | input | 1 | One instruction retired |
| shadow_set | input | 1 | Open a one-instruction shadow |
| shadow_kind | input | 2 | Shadow kinds: bit 0 external events, bit 1 debug traps |
| gie | input | 1 | Global event enable |
| if_flag | input | 1 | Maskable interrupt enable flag |
| tf_flag | input | 1 | Single-step flag |
| smi_evt | input | 1 | SMI pulse |
| init_evt | input | 1 | INIT pulse |
| init_block | input | 1 | Block recording of INIT |
| nmi_evt | input | 1 | NMI pulse |
| nmi_unblock | input | 1 | Clear NMI blocking |
| intr_req | input | 1 | Maskable interrupt request level |
| hold_req | input | 1 | Bus-hold request level |
| dbg_set | input | 16 | Debug-trap bits to merge |
| intack_vld | input | 1 | Interrupt controller returns a vector |
| intack_vec | input | 8 | Returned interrupt vector |
| intack_req | output | 1 | Acknowledge request to the interrupt controller |
| gnt | output | 6 | One-hot service grant |
| gnt_vec | output | 8 | Vector for the granted service |
| dbg_trap | output | 16 | Debug-trap register |
| nmi_blocked | output | 1 | Further NMIs are blocked |
| attention | output | 1 | Boundary processing is needed |

## Verification
The assertions take for granted that no boundary arrives while an acknowledge is outstanding. They also take for granted that the retired-instruction counter does not wrap within a shadow window, and that the interrupt controller answers each request exactly once. The directed stimulus follows these rules: every INTR grant is completed by a single `intack_vld` pulse before the next boundary, `dbg_set` and event pulses are driven in cycles of their own away from boundaries, and only a handful of retire pulses are issued. Under those rules the checks cover the ladder order, shadow expiry after two retires, the debug-bit filtering under a cleared global enable and NMI self-blocking.

// File: rtl/eba_pkg.sv
// Package: shared encodings for the instruction-boundary event arbiter.
// Assumes a 16-bit debug-trap register with fixed trap bit positions.
package eba_pkg;

    // Serviced event kinds; the value is the bit index in the grant vector.
    typedef enum logic [2:0] {
        SVC_DBG  = 3'd0,
        SVC_SMI  = 3'd1,
        SVC_INIT = 3'd2,
        SVC_NMI  = 3'd3,
        SVC_INTR = 3'd4,
        SVC_HOLD = 3'd5,
        SVC_NONE = 3'd6
    } svc_e;

    // Interrupt acknowledge handshake state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ack_st_e;

    localparam int SVC_COUNT = 6;
    localparam int RUNG_COUNT = 7;
    localparam int DBG_W = 16;
    localparam int SS_BIT = 14;
    localparam int TSW_BIT = 15;
    localparam int TRAP_HI = 15;
    localparam int TRAP_LO = 12;
    localparam logic [DBG_W-1:0] SS_MASK = DBG_W'(1) << SS_BIT;

    // Ladder rung to service mapping, highest priority at rung 0.
    function automatic svc_e rung_svc(input int rung);
        case (rung)
            0:       return SVC_DBG;
            1:       return SVC_SMI;
            2:       return SVC_INIT;
            3:       return SVC_DBG;
            4:       return SVC_NMI;
            5:       return SVC_INTR;
            6:       return SVC_HOLD;
            default: return SVC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/eba_shadow.sv
// Module: one-instruction shadow tracker.
// Counts retired instructions and records a shadow kind with a limit one
// past the current count; reports which kinds are blocked while the count
// is at or below that limit. Assumes the counter does not wrap in a window.
module eba_shadow #(
    parameter int CNT_W = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       retire,
    input  logic       shadow_set,
    input  logic [1:0] shadow_kind,
    output logic       intr_inh,
    output logic       dbg_inh
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;
    logic [1:0]       kind_q;
    logic             window;

    // Retired count, shadow limit and shadow kind registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lim_q  <= '0;
            kind_q <= '0;
        end else begin
            if (retire) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (shadow_set) begin
                lim_q  <= cnt_q + CNT_W'(1);
                kind_q <= shadow_kind;
            end
        end
    end

    // Shadow window and per-kind blocking.
    always_comb begin
        window   = (cnt_q <= lim_q);
        intr_inh = window && kind_q[0];
        dbg_inh  = window && kind_q[1];
    end

    p_shadow_intr_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_set && shadow_kind[0] |=> intr_inh);
    p_shadow_dbg_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_set && shadow_kind[1] |=> dbg_inh);

endmodule

// File: rtl/eba_dbgtrap.sv
// Module: debug-trap status register.
// Filters the register under a cleared global enable, clears or keeps it
// at each accepted boundary, adds the single-step bit when the step flag
// is set, and merges new trap bits on cycles without a boundary.
module eba_dbgtrap
    import eba_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gie,
    input  logic             tf_flag,
    input  logic             bnd_fire,
    input  logic             dbg_inh,
    input  logic             db_taken,
    input  logic [DBG_W-1:0] dbg_set,
    output logic [DBG_W-1:0] dbg_filt,
    output logic [DBG_W-1:0] dbg_q
);

    logic [DBG_W-1:0] kept;
    logic [DBG_W-1:0] bnd_next;

    // Boundary view of the register and its next value at a boundary.
    always_comb begin
        dbg_filt = gie ? dbg_q : (dbg_q & SS_MASK);
        if (db_taken) begin
            kept = '0;
        end else if (!dbg_inh && (dbg_filt[TRAP_HI:TRAP_LO] == '0)) begin
            kept = '0;
        end else begin
            kept = dbg_filt;
        end
        bnd_next = kept | (tf_flag ? SS_MASK : '0);
    end

    // Register update: boundary rule or merge of new trap bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_q <= '0;
        end else if (bnd_fire) begin
            dbg_q <= bnd_next;
        end else begin
            dbg_q <= dbg_q | dbg_set;
        end
    end

    p_gie_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_fire && !gie |=> (dbg_q & ~SS_MASK) == '0);
    p_db_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_fire && db_taken && !tf_flag |=> dbg_q == '0);

endmodule

// File: rtl/eba_evsel.sv
// Module: priority ladder, pending latches and acknowledge handshake.
// Picks one service per accepted boundary, holds SMI/INIT/NMI pending
// latches and NMI blocking, and runs the interrupt acknowledge exchange.
// Assumes no boundary is presented while an acknowledge is outstanding.
module eba_evsel
    import eba_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bnd_valid,
    input  logic                 gie,
    input  logic                 if_flag,
    input  logic                 intr_inh,
    input  logic                 dbg_inh,
    input  logic [DBG_W-1:0]     dbg_filt,
    input  logic                 smi_evt,
    input  logic                 init_evt,
    input  logic                 init_block,
    input  logic                 nmi_evt,
    input  logic                 nmi_unblock,
    input  logic                 intr_req,
    input  logic                 hold_req,
    input  logic                 intack_vld,
    input  logic [VEC_W-1:0]     intack_vec,
    output logic                 bnd_fire,
    output logic                 db_taken,
    output logic                 intack_req,
    output logic [SVC_COUNT-1:0] gnt,
    output logic [VEC_W-1:0]     gnt_vec,
    output logic                 nmi_blocked,
    output logic                 smi_pend,
    output logic                 init_pend,
    output logic                 nmi_pend
);

    localparam logic [VEC_W-1:0] VEC_DB  = VEC_W'(1);
    localparam logic [VEC_W-1:0] VEC_NMI = VEC_W'(2);

    ack_st_e               st_q;
    logic [RUNG_COUNT-1:0] rung;
    logic                  ext_ok;
    logic                  win_valid;
    svc_e                  win_svc;
    logic                  take_smi;
    logic                  take_init;
    logic                  take_nmi;
    logic                  take_intr;

    // Ladder rung qualification.
    always_comb begin
        ext_ok  = gie && !intr_inh;
        rung[0] = dbg_filt[TSW_BIT];
        rung[1] = gie && smi_pend;
        rung[2] = gie && init_pend;
        rung[3] = !dbg_inh && (dbg_filt[TRAP_HI:TRAP_LO] != '0);
        rung[4] = ext_ok && nmi_pend && !nmi_blocked;
        rung[5] = ext_ok && intr_req && if_flag;
        rung[6] = ext_ok && hold_req;
    end

    // Priority pick: the lowest qualified rung wins.
    always_comb begin
        win_valid = 1'b0;
        win_svc   = SVC_NONE;
        for (int i = RUNG_COUNT - 1; i >= 0; i--) begin
            if (rung[i]) begin
                win_valid = 1'b1;
                win_svc   = rung_svc(i);
            end
        end
    end

    // Boundary acceptance and per-service take strobes.
    always_comb begin
        bnd_fire   = bnd_valid && (st_q == ST_IDLE);
        db_taken   = bnd_fire && win_valid && (win_svc == SVC_DBG);
        take_smi   = bnd_fire && win_valid && (win_svc == SVC_SMI);
        take_init  = bnd_fire && win_valid && (win_svc == SVC_INIT);
        take_nmi   = bnd_fire && win_valid && (win_svc == SVC_NMI);
        take_intr  = bnd_fire && win_valid && (win_svc == SVC_INTR);
        intack_req = (st_q == ST_WAIT);
    end

    // Grant pulse, vector and acknowledge state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt     <= '0;
            gnt_vec <= '0;
            st_q    <= ST_IDLE;
        end else begin
            gnt     <= '0;
            gnt_vec <= '0;
            if (st_q == ST_WAIT) begin
                if (intack_vld) begin
                    gnt[SVC_INTR] <= 1'b1;
                    gnt_vec       <= intack_vec;
                    st_q          <= ST_IDLE;
                end
            end else if (bnd_fire && win_valid) begin
                case (win_svc)
                    SVC_DBG: begin
                        gnt[SVC_DBG] <= 1'b1;
                        gnt_vec      <= VEC_DB;
                    end
                    SVC_SMI:  gnt[SVC_SMI]  <= 1'b1;
                    SVC_INIT: gnt[SVC_INIT] <= 1'b1;
                    SVC_NMI: begin
                        gnt[SVC_NMI] <= 1'b1;
                        gnt_vec      <= VEC_NMI;
                    end
                    SVC_INTR: st_q <= ST_WAIT;
                    SVC_HOLD: gnt[SVC_HOLD] <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // Pending latches and NMI blocking; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_pend    <= 1'b0;
            init_pend   <= 1'b0;
            nmi_pend    <= 1'b0;
            nmi_blocked <= 1'b0;
        end else begin
            smi_pend    <= smi_evt || (smi_pend && !take_smi);
            init_pend   <= (init_evt && !init_block) || (init_pend && !take_init);
            nmi_pend    <= nmi_evt || (nmi_pend && !take_nmi);
            nmi_blocked <= take_nmi || (nmi_blocked && !nmi_unblock);
        end
    end

    p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    p_smi_needs_gie_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[SVC_SMI] |-> $past(gie));
    p_ext_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt[SVC_NMI] || gnt[SVC_HOLD]) |-> $past(gie && !intr_inh));
    p_nmi_self_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[SVC_NMI] |-> nmi_blocked && (gnt_vec == VEC_NMI));
    p_ack_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        intack_req && !intack_vld |=> intack_req);
    p_ack_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        intack_req && intack_vld |=> gnt[SVC_INTR] && (gnt_vec == $past(intack_vec)));
    p_no_bnd_in_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        intack_req |-> !bnd_valid);

endmodule

// File: rtl/evt_boundary_arbiter.sv
// Module: instruction-boundary event priority arbiter (top).
// Ties the shadow tracker, debug-trap register and priority ladder
// together and derives the attention output from the pending state.
// Assumes boundaries are presented only while intack_req is low.
module evt_boundary_arbiter
    import eba_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bnd_valid,
    input  logic                 retire,
    input  logic                 shadow_set,
    input  logic [1:0]           shadow_kind,
    input  logic                 gie,
    input  logic                 if_flag,
    input  logic                 tf_flag,
    input  logic                 smi_evt,
    input  logic                 init_evt,
    input  logic                 init_block,
    input  logic                 nmi_evt,
    input  logic                 nmi_unblock,
    input  logic                 intr_req,
    input  logic                 hold_req,
    input  logic [DBG_W-1:0]     dbg_set,
    input  logic                 intack_vld,
    input  logic [VEC_W-1:0]     intack_vec,
    output logic                 intack_req,
    output logic [SVC_COUNT-1:0] gnt,
    output logic [VEC_W-1:0]     gnt_vec,
    output logic [DBG_W-1:0]     dbg_trap,
    output logic                 nmi_blocked,
    output logic                 attention
);

    logic             intr_inh;
    logic             dbg_inh;
    logic             bnd_fire;
    logic             db_taken;
    logic [DBG_W-1:0] dbg_filt;
    logic             smi_pend;
    logic             init_pend;
    logic             nmi_pend;

    eba_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .retire      (retire),
        .shadow_set  (shadow_set),
        .shadow_kind (shadow_kind),
        .intr_inh    (intr_inh),
        .dbg_inh     (dbg_inh)
    );

    eba_dbgtrap u_dbgtrap (
        .clk      (clk),
        .rst_n    (rst_n),
        .gie      (gie),
        .tf_flag  (tf_flag),
        .bnd_fire (bnd_fire),
        .dbg_inh  (dbg_inh),
        .db_taken (db_taken),
        .dbg_set  (dbg_set),
        .dbg_filt (dbg_filt),
        .dbg_q    (dbg_trap)
    );

    eba_evsel #(.VEC_W(VEC_W)) u_evsel (
        .clk         (clk),
        .rst_n       (rst_n),
        .bnd_valid   (bnd_valid),
        .gie         (gie),
        .if_flag     (if_flag),
        .intr_inh    (intr_inh),
        .dbg_inh     (dbg_inh),
        .dbg_filt    (dbg_filt),
        .smi_evt     (smi_evt),
        .init_evt    (init_evt),
        .init_block  (init_block),
        .nmi_evt     (nmi_evt),
        .nmi_unblock (nmi_unblock),
        .intr_req    (intr_req),
        .hold_req    (hold_req),
        .intack_vld  (intack_vld),
        .intack_vec  (intack_vec),
        .bnd_fire    (bnd_fire),
        .db_taken    (db_taken),
        .intack_req  (intack_req),
        .gnt         (gnt),
        .gnt_vec     (gnt_vec),
        .nmi_blocked (nmi_blocked),
        .smi_pend    (smi_pend),
        .init_pend   (init_pend),
        .nmi_pend    (nmi_pend)
    );

    // Attention: anything that the next boundary would have to look at.
    always_comb begin
        attention = (|dbg_trap) || hold_req ||
                    (gie && (smi_pend || init_pend || (nmi_pend && !nmi_blocked) ||
                             (intr_req && if_flag)));
    end

    p_attention_dbg_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_trap != '0) |-> attention);

endmodule

// File: tb/test_evt_boundary_arbiter.sv
// Directed bench for the instruction-boundary event priority arbiter.
module test_evt_boundary_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bnd_valid = 1'b0;
    logic        retire = 1'b0;
    logic        shadow_set = 1'b0;
    logic [1:0]  shadow_kind = 2'b00;
    logic        gie = 1'b0;
    logic        if_flag = 1'b0;
    logic        tf_flag = 1'b0;
    logic        smi_evt = 1'b0;
    logic        init_evt = 1'b0;
    logic        init_block = 1'b0;
    logic        nmi_evt = 1'b0;
    logic        nmi_unblock = 1'b0;
    logic        intr_req = 1'b0;
    logic        hold_req = 1'b0;
    logic [15:0] dbg_set = '0;
    logic        intack_vld = 1'b0;
    logic [7:0]  intack_vec = '0;
    logic        intack_req;
    logic [5:0]  gnt;
    logic [7:0]  gnt_vec;
    logic [15:0] dbg_trap;
    logic        nmi_blocked;
    logic        attention;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    localparam logic [5:0] G_DBG  = 6'b000001;
    localparam logic [5:0] G_SMI  = 6'b000010;
    localparam logic [5:0] G_INIT = 6'b000100;
    localparam logic [5:0] G_NMI  = 6'b001000;
    localparam logic [5:0] G_INTR = 6'b010000;
    localparam logic [5:0] G_HOLD = 6'b100000;

    always #4 clk = ~clk;

    evt_boundary_arbiter i_evt_boundary_arbiter (
        .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .retire(retire),
        .shadow_set(shadow_set), .shadow_kind(shadow_kind), .gie(gie),
        .if_flag(if_flag), .tf_flag(tf_flag), .smi_evt(smi_evt),
        .init_evt(init_evt), .init_block(init_block), .nmi_evt(nmi_evt),
        .nmi_unblock(nmi_unblock), .intr_req(intr_req), .hold_req(hold_req),
        .dbg_set(dbg_set), .intack_vld(intack_vld), .intack_vec(intack_vec),
        .intack_req(intack_req), .gnt(gnt), .gnt_vec(gnt_vec),
        .dbg_trap(dbg_trap), .nmi_blocked(nmi_blocked), .attention(attention)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One accepted boundary; returns at the negedge after the sampling edge.
    task automatic boundary();
        @(negedge clk) bnd_valid = 1'b1;
        @(negedge clk) bnd_valid = 1'b0;
    endtask

    task automatic do_retire();
        @(negedge clk) retire = 1'b1;
        @(negedge clk) retire = 1'b0;
    endtask

    task automatic open_shadow(input logic [1:0] kind);
        @(negedge clk) begin shadow_set = 1'b1; shadow_kind = kind; end
        @(negedge clk) begin shadow_set = 1'b0; shadow_kind = 2'b00; end
    endtask

    task automatic t_reset();
        chk("R1", "gnt", 32'(gnt), 0);
        chk("R1", "gnt_vec", 32'(gnt_vec), 0);
        chk("R1", "dbg_trap", 32'(dbg_trap), 0);
        chk("R1", "intack_req", 32'(intack_req), 0);
        chk("R1", "nmi_blocked", 32'(nmi_blocked), 0);
        chk("R1", "attention", 32'(attention), 0);
    endtask

    task automatic t_ladder();
        gie = 1'b1; if_flag = 1'b1;
        @(negedge clk) begin
            dbg_set = 16'h8000; smi_evt = 1'b1; init_evt = 1'b1; nmi_evt = 1'b1;
        end
        @(negedge clk) begin
            dbg_set = '0; smi_evt = 1'b0; init_evt = 1'b0; nmi_evt = 1'b0;
            intr_req = 1'b1; hold_req = 1'b1;
        end
        chk("R4", "merged task-switch bit", 32'(dbg_trap), 32'h8000);
        boundary();
        chk("R2", "task-switch trap first", 32'(gnt), 32'(G_DBG));
        chk("R2", "debug vector", 32'(gnt_vec), 1);
        chk("R4", "register cleared by trap", 32'(dbg_trap), 0);
        @(negedge clk);
        chk("R2", "grant lasts one cycle", 32'(gnt), 0);
        boundary();
        chk("R2", "SMI second", 32'(gnt), 32'(G_SMI));
        chk("R2", "SMI vector zero", 32'(gnt_vec), 0);
        boundary();
        chk("R3", "INIT after SMI, SMI pending cleared", 32'(gnt), 32'(G_INIT));
        boundary();
        chk("R7", "NMI next", 32'(gnt), 32'(G_NMI));
        chk("R7", "NMI vector", 32'(gnt_vec), 2);
        chk("R7", "NMI blocked", 32'(nmi_blocked), 1);
        boundary();
        chk("R8", "no grant before ack", 32'(gnt), 0);
        chk("R8", "ack requested", 32'(intack_req), 1);
        @(negedge clk);
        chk("R8", "ack request held", 32'(intack_req), 1);
        intack_vld = 1'b1; intack_vec = 8'hA5;
        @(negedge clk) begin intack_vld = 1'b0; intack_vec = '0; intr_req = 1'b0; end
        chk("R8", "INTR grant", 32'(gnt), 32'(G_INTR));
        chk("R8", "INTR vector", 32'(gnt_vec), 32'hA5);
        chk("R8", "ack request dropped", 32'(intack_req), 0);
        boundary();
        chk("R2", "hold last", 32'(gnt), 32'(G_HOLD));
        hold_req = 1'b0;
        boundary();
        chk("R2", "nothing left", 32'(gnt), 0);
    endtask

    task automatic t_gie_low();
        gie = 1'b0;
        @(negedge clk) begin smi_evt = 1'b1; dbg_set = 16'hA008; hold_req = 1'b1; end
        @(negedge clk) begin smi_evt = 1'b0; dbg_set = '0; end
        boundary();
        chk("R3", "SMI held off by gie", 32'(gnt), 0);
        chk("R6", "hold held off by gie", 32'(gnt), 0);
        chk("R5", "non-step bits dropped", 32'(dbg_trap), 0);
        @(negedge clk) dbg_set = 16'hE008;
        @(negedge clk) dbg_set = '0;
        open_shadow(2'b10);
        boundary();
        chk("R5", "only single-step kept", 32'(dbg_trap), 32'h4000);
        chk("R4", "debug shadow blocks trap", 32'(gnt), 0);
        gie = 1'b1; hold_req = 1'b0;
        boundary();
        chk("R3", "SMI taken once gie set", 32'(gnt), 32'(G_SMI));
        chk("R4", "bits kept while SMI wins", 32'(dbg_trap), 32'h4000);
        do_retire();
        boundary();
        chk("R9", "debug shadow after one retire", 32'(gnt), 0);
        do_retire();
        boundary();
        chk("R9", "debug shadow over after two retires", 32'(gnt), 32'(G_DBG));
        chk("R4", "register cleared", 32'(dbg_trap), 0);
    endtask

    task automatic t_intr_shadow();
        hold_req = 1'b1;
        open_shadow(2'b01);
        boundary();
        chk("R6", "interrupt shadow blocks hold", 32'(gnt), 0);
        do_retire();
        boundary();
        chk("R9", "shadow after one retire", 32'(gnt), 0);
        do_retire();
        boundary();
        chk("R9", "hold after shadow ends", 32'(gnt), 32'(G_HOLD));
        hold_req = 1'b0;
    endtask

    task automatic t_dbg_clear();
        @(negedge clk) dbg_set = 16'h0008;
        @(negedge clk) dbg_set = '0;
        chk("R4", "low bit merged", 32'(dbg_trap), 32'h0008);
        chk("R11", "attention from debug bits", 32'(attention), 1);
        boundary();
        chk("R4", "no trap for low bits", 32'(gnt), 0);
        chk("R4", "low bits cleared", 32'(dbg_trap), 0);
    endtask

    task automatic t_single_step();
        tf_flag = 1'b1;
        boundary();
        tf_flag = 1'b0;
        chk("R10", "step bit scheduled", 32'(dbg_trap), 32'h4000);
        chk("R10", "no trap yet", 32'(gnt), 0);
        boundary();
        chk("R10", "step trap fires", 32'(gnt), 32'(G_DBG));
        chk("R10", "register cleared", 32'(dbg_trap), 0);
    endtask

    task automatic t_nmi_mask();
        @(negedge clk) nmi_evt = 1'b1;
        @(negedge clk) nmi_evt = 1'b0;
        chk("R11", "blocked NMI gives no attention", 32'(attention), 0);
        boundary();
        chk("R7", "blocked NMI not taken", 32'(gnt), 0);
        @(negedge clk) nmi_unblock = 1'b1;
        @(negedge clk) nmi_unblock = 1'b0;
        chk("R7", "unblocked", 32'(nmi_blocked), 0);
        chk("R11", "unblocked NMI gives attention", 32'(attention), 1);
        boundary();
        chk("R7", "NMI taken after unblock", 32'(gnt), 32'(G_NMI));
        chk("R11", "attention clear afterwards", 32'(attention), 0);
    endtask

    task automatic t_init_block();
        @(negedge clk) begin init_block = 1'b1; init_evt = 1'b1; end
        @(negedge clk) begin init_block = 1'b0; init_evt = 1'b0; end
        boundary();
        chk("R3", "blocked INIT not recorded", 32'(gnt), 0);
    endtask

    task automatic t_if_flag();
        intr_req = 1'b1; if_flag = 1'b0;
        @(negedge clk);
        chk("R11", "no attention with IF clear", 32'(attention), 0);
        boundary();
        chk("R8", "no INTR with IF clear", 32'(gnt), 0);
        chk("R8", "no ack request with IF clear", 32'(intack_req), 0);
        if_flag = 1'b1;
        boundary();
        chk("R8", "ack requested with IF set", 32'(intack_req), 1);
        @(negedge clk) begin intack_vld = 1'b1; intack_vec = 8'h3C; end
        @(negedge clk) begin intack_vld = 1'b0; intr_req = 1'b0; end
        chk("R8", "INTR vector second pattern", 32'(gnt_vec), 32'h3C);
        hold_req = 1'b1;
        @(negedge clk);
        chk("R11", "attention from hold", 32'(attention), 1);
        hold_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ladder();
        t_gie_low();
        t_intr_shadow();
        t_dbg_clear();
        t_single_step();
        t_nmi_mask();
        t_init_block();
        t_if_flag();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule